// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A one-entry holding buffer sits in front of a frame shift register. Software can therefore hand over the next byte while the current frame is still on the line. When the shift register finishes a frame and a byte is waiting, the next frame starts on the very next bit period, with no idle time between the two frames. An external baud tick, one clock cycle wide, advances the line by one bit time.

Two status flags report progress. The buffer-empty flag shows that a new byte may be written. The done flag shows that the line has fully drained. Each flag drives a level interrupt request that is gated by its own enable bit. Three settings are configurable: the data length (5 to 8 bits), an even or odd parity bit, and one or two stop bits.

A transmit-enable level controls whether the block owns the line. When the level drops, the block keeps the line until every pending bit has been sent. Only then does it deassert the output-enable.

Top module: `uart_dbuf_tx`

## Requirements
- R1: A frame is one low start bit, then `cfg_len`+5 data bits sent LSB first, then the stop bits, which are high. `cfg_len` 0..3 selects 5..8 data bits. The line is high when no frame is being sent. Each bit lasts from one `baud_tick` cycle to the next.
- R2: When `cfg_par_en`=1, one parity bit follows the last data bit. It is the XOR of only the configured data bits, inverted when `cfg_par_odd`=1.
- R3: `cfg_two_stop`=1 sends two stop bits; 0 sends one.
- R4: `hold_empty` is 1 after reset. It goes to 0 in the cycle after a write is accepted. It returns to 1 when the byte moves into the shift register, on a `baud_tick`.
- R5: When a frame ends and a byte is held, the next start bit begins on the same tick, with no idle bit between the two frames.
- R6: A write is dropped when the holding buffer is full or `tx_enable` is 0. The line then carries no frame for the dropped byte.
- R7: `tx_done` sets when the last stop bit of a frame ends and no byte is held. It stays 0 between back-to-back frames.
- R8: `tx_done` clears on `done_ack` or on `done_clr`. If it is set in the same cycle as a clear, setting wins.
- R9: `irq_empty` is high while both `empty_ie` and `hold_empty` are 1. It stays high until a byte is written or the enable drops.
- R10: `irq_done` is high exactly while both `done_ie` and `tx_done` are 1.
- R11: After `tx_enable` falls, `txd_oe` stays 1 until the held byte and the frame in progress have both been sent completely.
- R12: While the transmitter is disabled, `txd_oe` is 0 and `txd` is 1.
- R13: After reset, `tx_done`=0, `txd_oe`=0, `txd`=1, and both interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| cfg_len | input | 2 | Data length select, 5 + value bits |
| cfg_par_en | input | 1 | Insert a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_two_stop | input | 1 | Send two stop bits |
| tx_enable | input | 1 | Transmit-enable request level |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| done_ack | input | 1 | Interrupt acknowledge for the done flag |
| done_clr | input | 1 | Write-one clear of the done flag |
| empty_ie | input | 1 | Buffer-empty interrupt enable |
| done_ie | input | 1 | Done interrupt enable |
| hold_empty | output | 1 | Holding buffer can accept a byte |
| tx_done | output | 1 | Line drained, sticky flag |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | Done interrupt request |
| txd | output | 1 | Serial line |
| txd_oe | output | 1 | Transmitter owns the line |

## Verification
A bad bit count or a bad parity mask shows up at `txd` within the first frame after a configuration change. Each bit is compared at the tick where it first appears. A buffer that loses its full state shows as a missing second frame or as an idle bit between frames. A done flag that sets too early shows as `tx_done` high while the second frame is still on the line. An enable that drops too soon shows as `txd_oe` falling in the middle of a frame, within one bit period.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    localparam int LEN_W = 2;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             par_en;
        logic             par_odd;
        logic             two_stop;
    } tx_cfg_t;
endpackage

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_enable,
    input  logic              take,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_data
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hb_t;

    hb_t  st_d, st_q;
    logic accept;

    always_comb begin
        st_d   = st_q;
        accept = wr_valid && !st_q.full && tx_enable;
        if (take) begin
            st_d.full = 1'b0;
        end
        if (accept) begin
            st_d.full = 1'b1;
            st_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_full = st_q.full;
    assign hold_data = st_q.data;

    p_accept_fills_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> hold_full);

    p_full_write_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && hold_full && !take) |=> (hold_full && $stable(hold_data)));
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  tx_cfg_t           cfg,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              finish,
    output logic              busy,
    output logic              line
);
    localparam int FRAME_W  = DATA_W + 4;
    localparam int CNT_W    = $clog2(FRAME_W + 1);
    localparam int MIN_BITS = DATA_W - (2 ** LEN_W) + 1;

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
        logic               line;
    } sh_t;

    sh_t                st_d, st_q;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;
    logic [CNT_W-1:0]   par_idx;
    logic [CNT_W-1:0]   total;
    logic               par;

    // Build the frame image for the held byte.
    always_comb begin
        nbits   = CNT_W'(MIN_BITS) + CNT_W'(cfg.len);
        par     = 1'b0;
        frame   = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (CNT_W'(i) < nbits) begin
                frame[i + 1] = hold_data[i];
                par          = par ^ hold_data[i];
            end
        end
        par_idx = nbits + CNT_W'(1);
        if (cfg.par_en) begin
            frame[par_idx] = par ^ cfg.par_odd;
        end
        total = nbits + CNT_W'(2) + CNT_W'(cfg.par_en) + CNT_W'(cfg.two_stop);
    end

    always_comb begin
        st_d   = st_q;
        take   = 1'b0;
        finish = 1'b0;
        if (baud_tick) begin
            if (st_q.busy && st_q.cnt != CNT_W'(1)) begin
                st_d.sr   = {1'b1, st_q.sr[FRAME_W-1:1]};
                st_d.line = st_q.sr[1];
                st_d.cnt  = st_q.cnt - CNT_W'(1);
            end else begin
                finish = st_q.busy;
                if (hold_full) begin
                    take      = 1'b1;
                    st_d.busy = 1'b1;
                    st_d.sr   = frame;
                    st_d.line = frame[0];
                    st_d.cnt  = total;
                end else begin
                    st_d.busy = 1'b0;
                    st_d.line = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.line <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign line = st_q.line;

    p_start_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !line);

    p_finish_on_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> line);

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line);
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_enable,
    input  logic finish,
    input  logic take,
    input  logic busy,
    input  logic hold_full,
    input  logic done_ack,
    input  logic done_clr,
    input  logic empty_ie,
    input  logic done_ie,
    output logic tx_done,
    output logic irq_empty,
    output logic irq_done,
    output logic active
);
    typedef struct packed {
        logic done;
        logic en;
    } ct_t;

    ct_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (done_ack || done_clr) begin
            st_d.done = 1'b0;
        end
        if (finish && !take) begin
            st_d.done = 1'b1;
        end
        st_d.en = tx_enable || (st_q.en && (busy || hold_full));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_done   = st_q.done;
    assign active    = st_q.en;
    assign irq_empty = empty_ie && !hold_full;
    assign irq_done  = done_ie && st_q.done;

    p_done_when_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> !busy);

    p_drain_before_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (busy || hold_full)) |=> active);

    p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !take) |=> tx_done);
endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              tx_enable,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              done_ack,
    input  logic              done_clr,
    input  logic              empty_ie,
    input  logic              done_ie,
    output logic              hold_empty,
    output logic              tx_done,
    output logic              irq_empty,
    output logic              irq_done,
    output logic              txd,
    output logic              txd_oe
);
    tx_cfg_t           cfg;
    logic              take, finish, busy, line, hold_full, active;
    logic [DATA_W-1:0] hold_data;

    assign cfg = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd,
                   two_stop: cfg_two_stop};

    uart_tx_holdbuf #(.DATA_W(DATA_W)) hold_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .tx_enable(tx_enable), .take(take), .hold_full(hold_full),
        .hold_data(hold_data)
    );

    uart_tx_shifter #(.DATA_W(DATA_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg(cfg),
        .hold_full(hold_full), .hold_data(hold_data), .take(take),
        .finish(finish), .busy(busy), .line(line)
    );

    uart_tx_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .finish(finish),
        .take(take), .busy(busy), .hold_full(hold_full), .done_ack(done_ack),
        .done_clr(done_clr), .empty_ie(empty_ie), .done_ie(done_ie),
        .tx_done(tx_done), .irq_empty(irq_empty), .irq_done(irq_done),
        .active(active)
    );

    assign hold_empty = !hold_full;
    assign txd_oe     = active;
    assign txd        = active ? line : 1'b1;

    p_released_line_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !txd_oe |-> txd);
endmodule

// File: tb/uart_dbuf_tx_tb_top.sv
module uart_dbuf_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       tx_enable = 1'b0, wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       done_ack = 1'b0, done_clr = 1'b0, empty_ie = 1'b0, done_ie = 1'b0;
    logic       hold_empty, tx_done, irq_empty, irq_done, txd, txd_oe;

    int   n_vec = 0;
    int   n_bad = 0;
    int   tcnt = 0;
    logic logging = 1'b0;
    logic log_bits [0:63];
    int   nlog = 0;

    always #2 clk = ~clk;

    uart_dbuf_tx dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .tx_enable(tx_enable),
        .wr_valid(wr_valid), .wr_data(wr_data), .done_ack(done_ack),
        .done_clr(done_clr), .empty_ie(empty_ie), .done_ie(done_ie),
        .hold_empty(hold_empty), .tx_done(tx_done), .irq_empty(irq_empty),
        .irq_done(irq_done), .txd(txd), .txd_oe(txd_oe)
    );

    // Tick generator and line logger: the line is read one half cycle after each tick edge.
    always @(negedge clk) begin
        if (baud_tick && logging && nlog < 64) begin
            log_bits[nlog] = txd;
            nlog = nlog + 1;
        end
        if (tcnt == 3) begin
            baud_tick <= 1'b1;
            tcnt = 0;
        end else begin
            baud_tick <= 1'b0;
            tcnt = tcnt + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_vec = n_vec + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_clear(input logic use_ack);
        @(negedge clk);
        if (use_ack) done_ack = 1'b1; else done_clr = 1'b1;
        @(negedge clk);
        done_ack = 1'b0;
        done_clr = 1'b0;
    endtask

    task automatic wait_empty();
        while (!hold_empty) @(negedge clk);
    endtask

    task automatic wait_done();
        while (!tx_done) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_frame(input logic [7:0] b);
        logic [15:0] v = '1;
        logic        p = 1'b0;
        int          nb = 5 + int'(cfg_len);
        v[0] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            v[1 + i] = b[i];
            p = p ^ b[i];
        end
        if (cfg_par_en) v[1 + nb] = p ^ cfg_par_odd;
        return v;
    endfunction

    function automatic int exp_len();
        return 7 + int'(cfg_len) + int'(cfg_par_en) + int'(cfg_two_stop);
    endfunction

    // Compare the logged line against nfr expected frames (back-to-back), then idle bits.
    task automatic check_stream(input logic [7:0] b0, input logic [7:0] b1, input int nfr,
                                input string req);
        int s = 0;
        int pos;
        int flen = exp_len();
        while (s < nlog && log_bits[s] == 1'b1) s++;
        pos = s;
        for (int f = 0; f < nfr; f++) begin
            logic [15:0] ef = exp_frame(f == 0 ? b0 : b1);
            logic [15:0] got = '1;
            for (int k = 0; k < flen; k++) begin
                got[k] = (pos + k < nlog) ? log_bits[pos + k] : 1'bx;
            end
            chk(got === ef, req, int'(got), int'(ef));
            pos = pos + flen;
        end
        for (int k = pos; k < nlog; k++) begin
            chk(log_bits[k] === 1'b1, "R1 idle-after-frame", int'(log_bits[k]), 1);
        end
    endtask

    task automatic pair(input logic [7:0] b0, input logic [7:0] b1);
        nlog = 0;
        logging = 1'b1;
        put(b0);
        wait_empty();
        put(b1);
        chk(tx_done == 1'b0, "R7 done-low-between-frames", int'(tx_done), 0);
        wait_done();
        repeat (12) @(negedge clk);
        logging = 1'b0;
        check_stream(b0, b1, 2, "R1 R2 R3 R5 frame-bits");
        pulse_clear(1'b0);
    endtask

    initial begin
        int cfgi = 0;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk(hold_empty == 1'b1, "R4 R13 reset-empty", int'(hold_empty), 1);
        chk(tx_done == 1'b0, "R13 reset-done", int'(tx_done), 0);
        chk(txd_oe == 1'b0 && txd == 1'b1, "R13 reset-line", int'({txd_oe, txd}), 1);
        chk(irq_empty == 1'b0 && irq_done == 1'b0, "R13 reset-irq",
            int'({irq_empty, irq_done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6 R12: write while disabled is dropped, line released
        nlog = 0;
        logging = 1'b1;
        put(8'h5A);
        chk(hold_empty == 1'b1, "R6 disabled-write-drop", int'(hold_empty), 1);
        repeat (40) @(negedge clk);
        logging = 1'b0;
        chk(txd_oe == 1'b0 && txd == 1'b1, "R12 disabled-line", int'({txd_oe, txd}), 1);
        check_stream(8'h00, 8'h00, 0, "R6 no-frame");

        tx_enable = 1'b1;
        repeat (2) @(negedge clk);
        chk(txd_oe == 1'b1, "R11 enable-oe", int'(txd_oe), 1);

        // R9 R4 R10 R8 interrupt and flag behaviour
        empty_ie = 1'b1;
        @(negedge clk);
        chk(irq_empty == 1'b1, "R9 irq-empty-level", int'(irq_empty), 1);
        put(8'hC3);
        chk(hold_empty == 1'b0, "R4 empty-clears-on-write", int'(hold_empty), 0);
        chk(irq_empty == 1'b0, "R9 irq-empty-drops", int'(irq_empty), 0);
        wait_empty();
        chk(irq_empty == 1'b1, "R9 irq-empty-refires", int'(irq_empty), 1);
        empty_ie = 1'b0;
        @(negedge clk);
        chk(irq_empty == 1'b0, "R9 irq-empty-masked", int'(irq_empty), 0);
        wait_done();
        chk(irq_done == 1'b0, "R10 irq-done-masked", int'(irq_done), 0);
        done_ie = 1'b1;
        @(negedge clk);
        chk(irq_done == 1'b1, "R10 irq-done-set", int'(irq_done), 1);
        pulse_clear(1'b1);
        chk(tx_done == 1'b0 && irq_done == 1'b0, "R8 ack-clears",
            int'({tx_done, irq_done}), 0);
        put(8'h3C);
        wait_done();
        pulse_clear(1'b0);
        chk(tx_done == 1'b0, "R8 w1c-clears", int'(tx_done), 0);
        done_ie = 1'b0;

        // R6: second write into a full buffer is dropped
        while (baud_tick != 1'b1) @(negedge clk);
        nlog = 0;
        logging = 1'b1;
        put(8'h96);
        put(8'h0F);
        wait_done();
        repeat (48) @(negedge clk);
        logging = 1'b0;
        check_stream(8'h96, 8'h00, 1, "R6 full-write-drop");
        pulse_clear(1'b0);

        // Configuration sweep: every length, parity mode and stop count
        for (int len = 0; len < 4; len++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int st = 0; st < 2; st++) begin
                    cfg_len      = 2'(len);
                    cfg_par_en   = (pm != 0);
                    cfg_par_odd  = (pm == 2);
                    cfg_two_stop = st[0];
                    pair(8'(cfgi * 37 + 5), ~8'(cfgi * 37 + 5));
                    pair(8'(cfgi * 91 + 200), 8'(cfgi * 13 + 7));
                    cfgi++;
                end
            end
        end

        // Every byte value, 8 bits with odd parity, two stop bits
        cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b1; cfg_two_stop = 1'b1;
        for (int b = 0; b < 256; b += 2) begin
            pair(8'(b), 8'(b + 1));
        end

        // R11: disable request during a pending pair waits for the drain
        cfg_len = 2'd0; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
        nlog = 0;
        logging = 1'b1;
        put(8'hA7);
        wait_empty();
        put(8'h52);
        @(negedge clk);
        tx_enable = 1'b0;
        repeat (8) @(negedge clk);
        chk(txd_oe == 1'b1, "R11 oe-held-while-pending", int'(txd_oe), 1);
        wait_done();
        repeat (12) @(negedge clk);
        logging = 1'b0;
        check_stream(8'hA7, 8'h52, 2, "R11 drained-frames");
        chk(txd_oe == 1'b0 && txd == 1'b1, "R11 R12 released-after-drain",
            int'({txd_oe, txd}), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad = n_bad + 1;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule